// File: doc/BRIEF.md
# Wait-State Flash Read Port

This block connects a 32-bit read bus to a flash array that always delivers a 64-bit doubleword. For each accepted request it works out which region the byte address falls in. It then serves the request from one of four places. A reserved address returns an error. An external cache hit is served directly. A doubleword buffer that already holds the aligned location serves a repeat access. Otherwise the block reads the array. An array read holds the bus for a programmable number of stall cycles. It then returns the selected 32-bit half and keeps the whole doubleword in the buffer, so a later access to the partner word completes without a stall.

The address map has three parts. The main array starts at byte 0. A separate user page sits at its own base address, and the block presents it to the array as the rows that follow the main array. Everything else is reserved. A small register sets the wait-state count. Software must pick a count that suits the clock. Writing the register, pulsing the flush input, or resetting the block empties the buffer.

Top module: `flash_rd_port`

## Requirements
- R1: After reset the wait-state count is 0 and the buffer is empty, so the first read of any location fetches from the array. With no request pending, rd_ready, rd_err and arr_en are low.
- R2: With a wait-state count of 0, every read completes in the cycle it is presented (rd_ready is high in that cycle), so one word is returned per clock.
- R3: With a wait-state count of N, a read that needs the array holds rd_ready low for exactly N cycles and raises it in cycle N+1. arr_en stays high in all N+1 cycles, and arr_addr carries the doubleword row index.
- R4: Byte address bit 2 selects the half of the doubleword. When it is 1, rd_rdata is bits 63:32; when it is 0, rd_rdata is bits 31:0.
- R5: After a fetch, a read of either word in the same aligned doubleword completes in its first cycle with arr_en low.
- R6: A read with cache_hit high, to a non-reserved address, completes in its first cycle. It returns cache_rdata, keeps arr_en low and leaves the buffer contents unchanged.
- R7: Byte addresses from USER_BASE up to USER_BASE + 8*USER_DW read the array at row MAIN_DW + (address - USER_BASE)/8. Main addresses below 8*MAIN_DW read row address/8.
- R8: Any other address completes in its first cycle with rd_err high and rd_rdata zero, and the array is not accessed. This takes priority over cache_hit.
- R9: Pulsing buf_flush, or writing the wait-state register (even with its current value), empties the buffer.
- R10: When ws_wr is high at a clock edge, ws_wdata becomes the wait-state count for reads from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_req | input | 1 | Read request; held with rd_addr until rd_ready |
| rd_addr | input | ADDR_W | Byte address of the 32-bit word |
| rd_ready | output | 1 | Request completes in this cycle |
| rd_rdata | output | 32 | Read data, valid with rd_ready |
| rd_err | output | 1 | Reserved-address response, with rd_ready |
| cache_hit | input | 1 | External cache holds the requested word |
| cache_rdata | input | 32 | Word supplied by the cache |
| ws_wr | input | 1 | Write strobe for the wait-state register |
| ws_wdata | input | WS_W | New wait-state count |
| buf_flush | input | 1 | Empty the doubleword buffer |
| arr_en | output | 1 | Array read active |
| arr_addr | output | IDX_W | Array doubleword row index |
| arr_rdata | input | 64 | Array read data, valid when the last stall ends |

## Verification
The bench builds the block with a 16-bit address, a 64-doubleword main array, a user page of 8 doublewords at 0x8000, and a 2-bit wait-state field. These small values put every boundary within a few dozen reads: the last main word, the first and last user words, the reserved gap on both sides, and the region above the user page. The 2-bit field lets the bench run the largest count of three stalls as well as 0, 1 and 2. The array model returns a word that encodes its row and half, so any wrong row index or wrong half-select shows up in the data.

// File: rtl/flash_rd_pkg.sv
// Package: shared types and helpers for the flash read port.
// Assumes a 64-bit array word split into two 32-bit bus words.
package flash_rd_pkg;

    // Region that a bus address falls into
    typedef enum logic [1:0] {
        RGN_MAIN = 2'd0,
        RGN_USER = 2'd1,
        RGN_RSVD = 2'd2
    } region_e;

    // Where the current response comes from
    typedef enum logic [2:0] {
        SRC_IDLE  = 3'd0,
        SRC_RSVD  = 3'd1,
        SRC_CACHE = 3'd2,
        SRC_BUF   = 3'd3,
        SRC_FETCH = 3'd4
    } src_e;

    // Pick one 32-bit half of a doubleword
    function automatic logic [31:0] pick_half(input logic [63:0] dw, input logic hi);
        return hi ? dw[63:32] : dw[31:0];
    endfunction

endpackage

// File: rtl/fr_addr_decode.sv
// Address decoder: sorts a byte address into main array, user page or
// reserved space, and forms the array row index. Assumes ADDR_W < 32
// and that the user page lies above the main array.
module fr_addr_decode #(
    parameter int ADDR_W    = 24,
    parameter int MAIN_DW   = 32768,
    parameter int USER_BASE = 24'h80_0000,
    parameter int USER_DW   = 64,
    parameter int IDX_W     = 16
) (
    input  logic [ADDR_W-1:0]         addr,
    output flash_rd_pkg::region_e     region,
    output logic [IDX_W-1:0]          row_idx,
    output logic                      hi_sel
);
    import flash_rd_pkg::*;

    localparam logic [31:0] MAIN_END = 32'(MAIN_DW * 8);
    localparam logic [31:0] USER_LO  = 32'(USER_BASE);
    localparam logic [31:0] USER_END = 32'(USER_BASE + USER_DW * 8);

    logic [31:0] a32;
    logic [31:0] user_row;

    assign a32 = 32'(addr);

    // Region classification
    always_comb begin
        if (a32 < MAIN_END)
            region = RGN_MAIN;
        else if (a32 >= USER_LO && a32 < USER_END)
            region = RGN_USER;
        else
            region = RGN_RSVD;
    end

    // Row index: user rows follow the main rows
    assign user_row = 32'(MAIN_DW) + ((a32 - USER_LO) >> 3);

    always_comb begin
        if (region == RGN_USER)
            row_idx = user_row[IDX_W-1:0];
        else
            row_idx = IDX_W'(a32 >> 3);
    end

    assign hi_sel = a32[2];

endmodule

// File: rtl/fr_wait_ctrl.sv
// Wait-state control: holds the programmed stall count and times
// each array fetch. A fetch of N wait states is done in cycle N+1.
// Assumes the requester holds its request steady until done.
module fr_wait_ctrl #(
    parameter int WS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ws_wr,
    input  logic [WS_W-1:0] ws_wdata,
    input  logic            fetch_act,
    output logic [WS_W-1:0] ws_q,
    output logic            fetch_done
);
    logic [WS_W-1:0] cnt_q;

    // Programmed wait-state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ws_q <= '0;
        else if (ws_wr)
            ws_q <= ws_wdata;
    end

    assign fetch_done = fetch_act && (cnt_q >= ws_q);

    // Cycles already spent on the current fetch
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!fetch_act || fetch_done)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/fr_dword_buf.sv
// One-entry doubleword buffer with row tag and valid bit. Loading
// wins over nothing; invalidation wins over loading.
module fr_dword_buf #(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inval,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [63:0]      load_data,
    input  logic [IDX_W-1:0] look_idx,
    input  logic             look_hi,
    output logic             hit,
    output logic [31:0]      hit_word
);
    import flash_rd_pkg::*;

    logic             vld_q;
    logic [IDX_W-1:0] tag_q;
    logic [63:0]      dat_q;

    // Valid bit: cleared by reset or invalidation, set on load
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= 1'b0;
        else if (inval)
            vld_q <= 1'b0;
        else if (load)
            vld_q <= 1'b1;
    end

    // Tag and data capture on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
            dat_q <= '0;
        end else if (load) begin
            tag_q <= load_idx;
            dat_q <= load_data;
        end
    end

    assign hit      = vld_q && (tag_q == look_idx);
    assign hit_word = pick_half(dat_q, look_hi);

endmodule

// File: rtl/flash_rd_port.sv
// Flash read port: serves 32-bit bus reads from a 64-bit flash array.
// Priority: reserved address, cache hit, buffer hit, array fetch.
// Assumes rd_addr and rd_req stay stable until rd_ready, and that the
// array returns row data on arr_rdata by the last cycle of a fetch.
module flash_rd_port #(
    parameter int ADDR_W    = 24,
    parameter int MAIN_DW   = 32768,
    parameter int USER_BASE = 24'h80_0000,
    parameter int USER_DW   = 64,
    parameter int WS_W      = 2,
    localparam int IDX_W    = $clog2(MAIN_DW + USER_DW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic [31:0]       rd_rdata,
    output logic              rd_err,
    input  logic              cache_hit,
    input  logic [31:0]       cache_rdata,
    input  logic              ws_wr,
    input  logic [WS_W-1:0]   ws_wdata,
    input  logic              buf_flush,
    output logic              arr_en,
    output logic [IDX_W-1:0]  arr_addr,
    input  logic [63:0]       arr_rdata
);
    import flash_rd_pkg::*;

    region_e          region;
    logic [IDX_W-1:0] row_idx;
    logic             hi_sel;
    logic             buf_hit;
    logic [31:0]      buf_word;
    logic [WS_W-1:0]  ws_q;
    logic             fetch_done;
    src_e             src;

    fr_addr_decode #(
        .ADDR_W(ADDR_W), .MAIN_DW(MAIN_DW), .USER_BASE(USER_BASE),
        .USER_DW(USER_DW), .IDX_W(IDX_W)
    ) u_dec (
        .addr(rd_addr), .region(region), .row_idx(row_idx), .hi_sel(hi_sel)
    );

    // Response source selection in priority order
    always_comb begin
        if (!rd_req)
            src = SRC_IDLE;
        else if (region == RGN_RSVD)
            src = SRC_RSVD;
        else if (cache_hit)
            src = SRC_CACHE;
        else if (buf_hit)
            src = SRC_BUF;
        else
            src = SRC_FETCH;
    end

    fr_wait_ctrl #(.WS_W(WS_W)) u_ws (
        .clk(clk), .rst_n(rst_n), .ws_wr(ws_wr), .ws_wdata(ws_wdata),
        .fetch_act(src == SRC_FETCH), .ws_q(ws_q), .fetch_done(fetch_done)
    );

    fr_dword_buf #(.IDX_W(IDX_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .inval(buf_flush || ws_wr),
        .load(fetch_done), .load_idx(row_idx), .load_data(arr_rdata),
        .look_idx(row_idx), .look_hi(hi_sel),
        .hit(buf_hit), .hit_word(buf_word)
    );

    assign arr_en   = (src == SRC_FETCH);
    assign arr_addr = arr_en ? row_idx : '0;

    // Handshake and error response
    always_comb begin
        rd_err   = (src == SRC_RSVD);
        rd_ready = (src == SRC_RSVD) || (src == SRC_CACHE) ||
                   (src == SRC_BUF)  || fetch_done;
    end

    // Read data mux
    always_comb begin
        case (src)
            SRC_CACHE: rd_rdata = cache_rdata;
            SRC_BUF:   rd_rdata = buf_word;
            SRC_FETCH: rd_rdata = fetch_done ? pick_half(arr_rdata, hi_sel) : '0;
            default:   rd_rdata = '0;
        endcase
    end

endmodule

// File: rtl/fr_checker.sv
// Checker for the flash read port, bound to the top module. Watches
// the bus handshake, error response, cache path and stall length.
module fr_checker #(
    parameter int ADDR_W    = 24,
    parameter int MAIN_DW   = 32768,
    parameter int USER_BASE = 24'h80_0000,
    parameter int USER_DW   = 64,
    parameter int WS_W      = 2,
    parameter int IDX_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ready,
    input logic [31:0]       rd_rdata,
    input logic              rd_err,
    input logic              cache_hit,
    input logic [31:0]       cache_rdata,
    input logic              arr_en,
    input logic [WS_W-1:0]   ws_q
);
    logic [31:0] a32;
    logic        rsvd;
    logic [7:0]  stall_run;

    assign a32  = 32'(rd_addr);
    assign rsvd = (a32 >= 32'(MAIN_DW * 8)) &&
                  ((a32 < 32'(USER_BASE)) || (a32 >= 32'(USER_BASE + USER_DW * 8)));

    // Consecutive stall cycles of the current request
    always_ff @(posedge clk) begin
        if (!rst_n || !rd_req || rd_ready)
            stall_run <= '0;
        else
            stall_run <= stall_run + 1'b1;
    end

    a_r8_rsvd_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rsvd) |-> (rd_ready && rd_err && rd_rdata == 32'd0 && !arr_en));

    a_r8_err_only_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_ready && rd_req && rsvd));

    a_r2_zero_ws: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && ws_q == '0) |-> rd_ready);

    a_r6_cache_path: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && cache_hit && !rsvd) |-> (rd_ready && !arr_en && rd_rdata == cache_rdata));

    a_r3_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ready) |-> (32'(stall_run) < 32'(ws_q)));

    a_r3_arr_during_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ready) |-> arr_en);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |-> (!rd_ready && !rd_err && !arr_en));

endmodule

bind flash_rd_port fr_checker #(
    .ADDR_W(ADDR_W), .MAIN_DW(MAIN_DW), .USER_BASE(USER_BASE),
    .USER_DW(USER_DW), .WS_W(WS_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_rdata(rd_rdata), .rd_err(rd_err),
    .cache_hit(cache_hit), .cache_rdata(cache_rdata),
    .arr_en(arr_en), .ws_q(ws_q)
);

// File: tb/sim_flash_rd_port.sv
`timescale 1ns/1ps
module sim_flash_rd_port;
    localparam int ADDR_W = 16;
    localparam int MAIN_DW = 64;
    localparam int USER_BASE = 16'h8000;
    localparam int USER_DW = 8;
    localparam int WS_W = 2;
    localparam int IDX_W = $clog2(MAIN_DW + USER_DW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_req = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic rd_ready, rd_err, arr_en;
    logic [31:0] rd_rdata;
    logic cache_hit = 1'b0;
    logic [31:0] cache_rdata = '0;
    logic ws_wr = 1'b0;
    logic [WS_W-1:0] ws_wdata = '0;
    logic buf_flush = 1'b0;
    logic [IDX_W-1:0] arr_addr;
    logic [63:0] arr_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    function automatic logic [31:0] word_of(input int row, input int hi);
        return 32'h5A00_0000 + 32'(row * 2 + hi);
    endfunction

    // Array model: row data encodes row number and half
    assign arr_rdata = arr_en ? {word_of(int'(arr_addr), 1), word_of(int'(arr_addr), 0)}
                              : 64'hBAD0_BAD0_BAD0_BAD0;

    flash_rd_port #(
        .ADDR_W(ADDR_W), .MAIN_DW(MAIN_DW), .USER_BASE(USER_BASE),
        .USER_DW(USER_DW), .WS_W(WS_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_rdata(rd_rdata), .rd_err(rd_err),
        .cache_hit(cache_hit), .cache_rdata(cache_rdata),
        .ws_wr(ws_wr), .ws_wdata(ws_wdata), .buf_flush(buf_flush),
        .arr_en(arr_en), .arr_addr(arr_addr), .arr_rdata(arr_rdata)
    );

    typedef struct packed {
        logic [1:0]  ws;
        logic [15:0] addr;
        logic        chit;
        logic        fetch;
        logic [1:0]  stalls;
        logic        err;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 16'h0000, 1'b0, 1'b1, 2'd0, 1'b0, 32'h5A00_0000}, // R2 R4
        '{2'd0, 16'h0004, 1'b0, 1'b0, 2'd0, 1'b0, 32'h5A00_0001}, // R5 R4
        '{2'd0, 16'h0108, 1'b0, 1'b1, 2'd0, 1'b0, 32'h5A00_0042}, // R2
        '{2'd1, 16'h0010, 1'b0, 1'b1, 2'd1, 1'b0, 32'h5A00_0004}, // R3 R10
        '{2'd1, 16'h0014, 1'b0, 1'b0, 2'd0, 1'b0, 32'h5A00_0005}, // R5
        '{2'd1, 16'h0010, 1'b0, 1'b0, 2'd0, 1'b0, 32'h5A00_0004}, // R5
        '{2'd1, 16'h0018, 1'b0, 1'b1, 2'd1, 1'b0, 32'h5A00_0006}, // R3
        '{2'd1, 16'h0020, 1'b1, 1'b0, 2'd0, 1'b0, 32'hCAC0_0020}, // R6
        '{2'd1, 16'h001C, 1'b0, 1'b0, 2'd0, 1'b0, 32'h5A00_0007}, // R6 buffer kept
        '{2'd1, 16'h0200, 1'b0, 1'b0, 2'd0, 1'b1, 32'h0000_0000}, // R8
        '{2'd1, 16'h7FFC, 1'b0, 1'b0, 2'd0, 1'b1, 32'h0000_0000}, // R8
        '{2'd1, 16'h8000, 1'b0, 1'b1, 2'd1, 1'b0, 32'h5A00_0080}, // R7
        '{2'd1, 16'h8004, 1'b0, 1'b0, 2'd0, 1'b0, 32'h5A00_0081}, // R7 R5
        '{2'd3, 16'h803C, 1'b0, 1'b1, 2'd3, 1'b0, 32'h5A00_008F}, // R7 R3
        '{2'd3, 16'h8040, 1'b0, 1'b0, 2'd0, 1'b1, 32'h0000_0000}, // R8
        '{2'd3, 16'h01FC, 1'b0, 1'b1, 2'd3, 1'b0, 32'h5A00_007F}, // R3 R7
        '{2'd2, 16'h01F8, 1'b0, 1'b1, 2'd2, 1'b0, 32'h5A00_007E}, // R9 R3
        '{2'd2, 16'h0200, 1'b1, 1'b0, 2'd0, 1'b1, 32'h0000_0000}, // R8 over cache
        '{2'd0, 16'h0004, 1'b0, 1'b1, 2'd0, 1'b0, 32'h5A00_0001}  // R9 R2
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int row_of(input logic [15:0] a);
        return (a < 16'h8000) ? int'(a >> 3) : MAIN_DW + int'((a - 16'h8000) >> 3);
    endfunction

    task automatic write_ws(input logic [WS_W-1:0] v);
        ws_wr = 1'b1; ws_wdata = v;
        @(negedge clk);
        ws_wr = 1'b0;
    endtask

    // Issue one read at a falling edge; report stalls, data, error, array use
    task automatic do_read(input logic [15:0] a, input logic ch, input logic exp_fetch,
                           output int stalls, output logic [31:0] data,
                           output logic err, output bit arr_ok);
        int row;
        row = row_of(a);
        stalls = 0; arr_ok = 1'b1;
        rd_req = 1'b1; rd_addr = a; cache_hit = ch; cache_rdata = 32'hCAC0_0000 | 32'(a);
        forever begin
            #1;
            if (exp_fetch) begin
                if (!(arr_en && int'(arr_addr) == row)) arr_ok = 1'b0;
            end else if (arr_en) arr_ok = 1'b0;
            if (rd_ready || stalls > 8) break;
            stalls++;
            @(negedge clk);
        end
        data = rd_rdata; err = rd_err;
        @(negedge clk);
        rd_req = 1'b0; cache_hit = 1'b0;
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int st;
        logic [31:0] d;
        logic e;
        bit ao;
        logic [WS_W-1:0] cur_ws;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle outputs after reset
        check(!rd_ready && !rd_err && !arr_en, "R1 idle outputs",
              {29'd0, rd_ready, rd_err, arr_en}, 32'd0);
        @(negedge clk);

        cur_ws = '0;
        for (int i = 0; i < NV; i++) begin
            if (TBL[i].ws != cur_ws) begin
                write_ws(TBL[i].ws); // R10
                cur_ws = TBL[i].ws;
            end
            do_read(TBL[i].addr, TBL[i].chit, TBL[i].fetch, st, d, e, ao);
            check(d == TBL[i].data, $sformatf("R4 data row %0d", i), d, TBL[i].data);
            check(e == TBL[i].err, $sformatf("R8 err row %0d", i), 32'(e), 32'(TBL[i].err));
            check(st == int'(TBL[i].stalls), $sformatf("R3 stalls row %0d", i),
                  32'(st), 32'(TBL[i].stalls));
            check(ao, $sformatf("R7 array use row %0d", i), 32'(ao), 32'd1);
        end

        // R9: flush empties the buffer
        write_ws(2'd1);
        do_read(16'h0030, 1'b0, 1'b1, st, d, e, ao);
        check(st == 1 && d == 32'h5A00_000C, "R9 fill before flush", d, 32'h5A00_000C);
        buf_flush = 1'b1;
        @(negedge clk);
        buf_flush = 1'b0;
        do_read(16'h0034, 1'b0, 1'b1, st, d, e, ao);
        check(st == 1 && ao, "R9 flush forces refetch", 32'(st), 32'd1);
        check(d == 32'h5A00_000D, "R9 data after flush", d, 32'h5A00_000D);

        // R9: rewriting the same count empties the buffer
        write_ws(2'd1);
        do_read(16'h0030, 1'b0, 1'b1, st, d, e, ao);
        check(st == 1 && ao, "R9 same-value write forces refetch", 32'(st), 32'd1);
        do_read(16'h0034, 1'b0, 1'b0, st, d, e, ao);
        check(st == 0 && ao && d == 32'h5A00_000D, "R5 partner after refetch", d, 32'h5A00_000D);

        // R1: reset empties the buffer and clears the count
        do_read(16'h0040, 1'b0, 1'b1, st, d, e, ao);
        check(st == 1 && d == 32'h5A00_0010, "R3 fill before reset", d, 32'h5A00_0010);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(16'h0044, 1'b0, 1'b1, st, d, e, ao);
        check(st == 0, "R1 count zero after reset", 32'(st), 32'd0);
        check(ao && d == 32'h5A00_0011, "R1 buffer empty after reset", d, 32'h5A00_0011);

        // R2: back-to-back reads at zero wait states, one per cycle
        rd_req = 1'b1;
        for (int k = 0; k < 4; k++) begin
            rd_addr = 16'(16'h0100 + k * 8);
            #1;
            check(rd_ready && rd_rdata == word_of(32 + k, 0), "R2 streaming read",
                  rd_rdata, word_of(32 + k, 0));
            @(negedge clk);
        end
        rd_req = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule